// File: doc/BRIEF.md
# Multi-Port GPIO Bank with Key-Scan and Comparator Interrupts

This block is the general-purpose pin peripheral of a small controller. It presents five 8-bit bidirectional ports, an 8-bit input-only port meant for key scanning, and a 16-bit output-only port behind a simple register bus. The bus has an address, a write enable and write data, and it returns read data combinationally from the current address. Each bidirectional pin has an output latch and a direction bit of its own. A pin whose direction bit is 0 floats as an input. A pin whose direction bit is 1 drives its latch value.

Every pad input passes through a two-flop synchroniser. The input-only port keeps a sticky pending flag that any change on its synchronised pins sets. Software clears the flag by writing a one to it. A one-bit comparator result, modelled here as a digital input, raises a second sticky flag on a selectable edge, but only while the comparator is enabled. While the comparator is enabled, it takes two pins of the fourth bidirectional port and forces them to be inputs. A configuration register holds the comparator enable, its edge select and the pull-up enable for the input-only port. The pull-up enable leaves the block as a pin-level control.

Top module: `gpio_bank`

## Requirements
- R1: After reset every pin output enable is 0, every output latch and the 16-bit output port are 0, both interrupts are low, and the configuration register reads 0.
- R2: Bidirectional port k (k = 0..4) has its direction register at byte address 8k+4. Bit value 1 makes the pin an output and drives `pinOe`. Reading the register returns the value written.
- R3: Port k has its data register at byte address 8k. A write sets the output latch, which appears on `pinOut`. A read returns the latch for output bits and the synchronised pin level for input bits. A pin change shows in the read data 2 clock edges after it is applied, and not after 1.
- R4: Reads and writes of one port's registers leave the other ports' registers unchanged.
- R5: The input-only port reads at address 0x28 as its synchronised pins, 2 edges after a change. Writes to 0x28 have no effect.
- R6: A write to 0x2C sets the 16-bit output port on the next edge. Reading 0x2C returns that value.
- R7: The configuration register is at 0x30. Bit 0 is the pull-up enable, driven on `pullUpEnF`. Bit 1 is the comparator enable. Bit 2 is the edge select: 1 means rising and 0 means falling.
- R8: A change on any synchronised input-only pin sets status bit 0 at 0x34 and `irqPortF` 3 edges after the change. The flag stays set until a write with bit 0 = 1 to 0x34. A write with bit 0 = 0 leaves it set.
- R9: The selected edge of the synchronised comparator input sets status bit 1 and `irqCmp`, but only while the comparator is enabled. A write with bit 1 = 1 to 0x34 clears it. The other edge does not set it.
- R10: While the comparator is enabled, the output enables of bits 4 and 5 of port 3 are 0, whatever the direction register holds. When the comparator is disabled, they follow the direction register again.
- R11: Unmapped or misaligned addresses read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 6 | Byte address |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | 16 | Write data |
| busRdData | output | 16 | Read data for busAddr |
| pinIn | input | 40 | Pad levels of the five bidirectional ports, port k at bits 8k+7..8k |
| pinOut | output | 40 | Output latches of the bidirectional ports |
| pinOe | output | 40 | Output enables, 1 = driven |
| portFIn | input | 8 | Input-only port pad levels |
| pullUpEnF | output | 1 | Pull-up enable for the input-only port |
| portGOut | output | 16 | Output-only port |
| cmpIn | input | 1 | Comparator result |
| irqPortF | output | 1 | Input-only port change interrupt |
| irqCmp | output | 1 | Comparator edge interrupt |

## Verification
Register writes take effect on the clock edge that samples the strobe, so outputs and read-back are checked half a cycle later. A pin change reaches the read data after 2 edges and a pending flag after 3 edges. The bench applies stimulus on a falling edge, counts rising edges explicitly and samples on the next falling edge. For R3 and R8 it also samples one edge early to confirm that the result is not yet visible. The sweep sets direction, latch and pin patterns on every bidirectional port and computes the expected read value as a bitwise merge of latch and pins.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned MAX_BIDIR = 8;
  localparam logic [7:0] ADDR_PORTF = 8'h28;
  localparam logic [7:0] ADDR_PORTG = 8'h2C;
  localparam logic [7:0] ADDR_CFG   = 8'h30;
  localparam logic [7:0] ADDR_STAT  = 8'h34;

  typedef enum logic [2:0] {
    RD_NONE, RD_DATA, RD_DIR, RD_PORTF, RD_PORTG, RD_CFG, RD_STAT
  } rdSel_e;

  typedef struct packed {
    logic [MAX_BIDIR-1:0] wrData;
    logic [MAX_BIDIR-1:0] wrDir;
    logic                 wrG;
    logic                 wrCfg;
    logic                 wrAck;
    rdSel_e               rdSel;
    logic [2:0]           rdPort;
  } busStrobe_t;
endpackage

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_BIDIR = 5,
  parameter int unsigned ADDR_W    = 6
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output busStrobe_t        strobe
);
  logic [2:0] portIdx;
  logic       aligned;
  logic       inBidir;

  assign portIdx = busAddr[5:3];
  assign aligned = (busAddr[1:0] == 2'b00) && ((busAddr >> 6) == '0);
  assign inBidir = aligned && (int'(portIdx) < NUM_BIDIR);

  always_comb begin
    strobe        = '0;
    strobe.rdSel  = RD_NONE;
    strobe.rdPort = portIdx;
    if (inBidir) begin
      if (busAddr[2]) begin
        strobe.rdSel          = RD_DIR;
        strobe.wrDir[portIdx] = busWrEn;
      end else begin
        strobe.rdSel           = RD_DATA;
        strobe.wrData[portIdx] = busWrEn;
      end
    end else if (busAddr == ADDR_W'(ADDR_PORTF)) begin
      strobe.rdSel = RD_PORTF;
    end else if (busAddr == ADDR_W'(ADDR_PORTG)) begin
      strobe.rdSel = RD_PORTG;
      strobe.wrG   = busWrEn;
    end else if (busAddr == ADDR_W'(ADDR_CFG)) begin
      strobe.rdSel = RD_CFG;
      strobe.wrCfg = busWrEn;
    end else if (busAddr == ADDR_W'(ADDR_STAT)) begin
      strobe.rdSel = RD_STAT;
      strobe.wrAck = busWrEn;
    end
  end
endmodule

// File: rtl/gpio_bank_datapath.sv
module gpio_bank_datapath
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_BIDIR = 5,
  parameter int unsigned PORT_W    = 8,
  parameter int unsigned OUT_W     = 16,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned CMP_PORT  = 3,
  parameter int unsigned CMP_LO    = 4,
  localparam int unsigned BIDIR_W  = NUM_BIDIR * PORT_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  busStrobe_t         strobe,
  input  logic [DATA_W-1:0]  busWrData,
  output logic [DATA_W-1:0]  busRdData,
  input  logic [BIDIR_W-1:0] pinIn,
  output logic [BIDIR_W-1:0] pinOut,
  output logic [BIDIR_W-1:0] pinOe,
  input  logic [PORT_W-1:0]  portFIn,
  output logic               pullUpEnF,
  output logic [OUT_W-1:0]   portGOut,
  input  logic               cmpIn,
  output logic               irqPortF,
  output logic               irqCmp,
  output logic               cmpEnable
);
  localparam logic [BIDIR_W-1:0] CMP_MASK =
    BIDIR_W'(2'b11) << (CMP_PORT * PORT_W + CMP_LO);

  logic [BIDIR_W-1:0] outLatch, dirReg, pinSync1, pinSync2;
  logic [PORT_W-1:0]  fSync1, fSync2, fPrev;
  logic               cSync1, cSync2, cPrev;
  logic [2:0]         cfgReg;
  logic               pendF, pendCmp;
  logic [PORT_W-1:0]  portRead [NUM_BIDIR];
  logic               cmpHit, fChange, edgeRise;

  assign pullUpEnF = cfgReg[0];
  assign cmpEnable = cfgReg[1];
  assign edgeRise  = cfgReg[2];
  assign pinOut    = outLatch;
  assign pinOe     = dirReg & ~(cmpEnable ? CMP_MASK : '0);
  assign portGOut  = gRegOut;
  assign irqPortF  = pendF;
  assign irqCmp    = pendCmp;

  logic [OUT_W-1:0] gRegOut;

  for (genvar k = 0; k < NUM_BIDIR; k++) begin : g_port
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        outLatch[k*PORT_W +: PORT_W] <= '0;
        dirReg[k*PORT_W +: PORT_W]   <= '0;
      end else begin
        if (strobe.wrData[k]) outLatch[k*PORT_W +: PORT_W] <= busWrData[PORT_W-1:0];
        if (strobe.wrDir[k])  dirReg[k*PORT_W +: PORT_W]   <= busWrData[PORT_W-1:0];
      end
    end
    assign portRead[k] = (pinSync2[k*PORT_W +: PORT_W] & ~pinOe[k*PORT_W +: PORT_W])
                       | (outLatch[k*PORT_W +: PORT_W] &  pinOe[k*PORT_W +: PORT_W]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pinSync1 <= '0; pinSync2 <= '0;
      fSync1 <= '0; fSync2 <= '0; fPrev <= '0;
      cSync1 <= 1'b0; cSync2 <= 1'b0; cPrev <= 1'b0;
    end else begin
      pinSync1 <= pinIn;   pinSync2 <= pinSync1;
      fSync1 <= portFIn;   fSync2 <= fSync1;   fPrev <= fSync2;
      cSync1 <= cmpIn;     cSync2 <= cSync1;   cPrev <= cSync2;
    end
  end

  assign fChange = (fSync2 != fPrev);
  assign cmpHit  = cmpEnable & (edgeRise ? (cSync2 & ~cPrev) : (~cSync2 & cPrev));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gRegOut <= '0;
      cfgReg  <= '0;
      pendF   <= 1'b0;
      pendCmp <= 1'b0;
    end else begin
      if (strobe.wrG)   gRegOut <= busWrData[OUT_W-1:0];
      if (strobe.wrCfg) cfgReg  <= busWrData[2:0];
      pendF   <= (pendF   & ~(strobe.wrAck & busWrData[0])) | fChange;
      pendCmp <= (pendCmp & ~(strobe.wrAck & busWrData[1])) | cmpHit;
    end
  end

  always_comb begin
    busRdData = '0;
    unique case (strobe.rdSel)
      RD_DATA: begin
        for (int k = 0; k < NUM_BIDIR; k++)
          if (int'(strobe.rdPort) == k) busRdData = DATA_W'(portRead[k]);
      end
      RD_DIR: begin
        for (int k = 0; k < NUM_BIDIR; k++)
          if (int'(strobe.rdPort) == k) busRdData = DATA_W'(dirReg[k*PORT_W +: PORT_W]);
      end
      RD_PORTF: busRdData = DATA_W'(fSync2);
      RD_PORTG: busRdData = DATA_W'(gRegOut);
      RD_CFG:   busRdData = DATA_W'(cfgReg);
      RD_STAT:  busRdData = DATA_W'({pendCmp, pendF});
      default:  busRdData = '0;
    endcase
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_BIDIR = 5,
  parameter int unsigned PORT_W    = 8,
  parameter int unsigned OUT_W     = 16,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned ADDR_W    = 6,
  parameter int unsigned CMP_PORT  = 3,
  parameter int unsigned CMP_LO    = 4,
  localparam int unsigned BIDIR_W  = NUM_BIDIR * PORT_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busWrEn,
  input  logic [DATA_W-1:0]  busWrData,
  output logic [DATA_W-1:0]  busRdData,
  input  logic [BIDIR_W-1:0] pinIn,
  output logic [BIDIR_W-1:0] pinOut,
  output logic [BIDIR_W-1:0] pinOe,
  input  logic [PORT_W-1:0]  portFIn,
  output logic               pullUpEnF,
  output logic [OUT_W-1:0]   portGOut,
  input  logic               cmpIn,
  output logic               irqPortF,
  output logic               irqCmp
);
  busStrobe_t strobe;
  logic       cmpEnable;

  gpio_bank_ctrl #(.NUM_BIDIR(NUM_BIDIR), .ADDR_W(ADDR_W)) u_ctrl (
    .busAddr(busAddr), .busWrEn(busWrEn), .strobe(strobe)
  );

  gpio_bank_datapath #(
    .NUM_BIDIR(NUM_BIDIR), .PORT_W(PORT_W), .OUT_W(OUT_W), .DATA_W(DATA_W),
    .CMP_PORT(CMP_PORT), .CMP_LO(CMP_LO)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busWrData(busWrData),
    .busRdData(busRdData), .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe),
    .portFIn(portFIn), .pullUpEnF(pullUpEnF), .portGOut(portGOut),
    .cmpIn(cmpIn), .irqPortF(irqPortF), .irqCmp(irqCmp), .cmpEnable(cmpEnable)
  );
endmodule

// File: rtl/gpio_bank_checker.sv
module gpio_bank_checker #(
  parameter int unsigned NUM_BIDIR = 5,
  parameter int unsigned PORT_W    = 8,
  parameter int unsigned OUT_W     = 16,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned ADDR_W    = 6,
  parameter int unsigned CMP_PORT  = 3,
  parameter int unsigned CMP_LO    = 4,
  localparam int unsigned BIDIR_W  = NUM_BIDIR * PORT_W
) (
  input logic               clk,
  input logic               rstN,
  input logic [ADDR_W-1:0]  busAddr,
  input logic               busWrEn,
  input logic [DATA_W-1:0]  busWrData,
  input logic [BIDIR_W-1:0] pinOe,
  input logic [OUT_W-1:0]   portGOut,
  input logic               irqPortF,
  input logic               irqCmp,
  input logic               cmpEnable
);
  localparam int unsigned PIN_LO = CMP_PORT * PORT_W + CMP_LO;
  logic ackF, ackCmp, wrG;
  assign ackF   = busWrEn && (busAddr == ADDR_W'(8'h34)) && busWrData[0];
  assign ackCmp = busWrEn && (busAddr == ADDR_W'(8'h34)) && busWrData[1];
  assign wrG    = busWrEn && (busAddr == ADDR_W'(8'h2C));

  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (pinOe == '0 && portGOut == '0 && !irqPortF && !irqCmp));

  a_r6_g_write: assert property (@(posedge clk) disable iff (!rstN)
    wrG |=> portGOut == $past(busWrData[OUT_W-1:0]));

  a_r8_irq_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (irqPortF && !ackF) |=> irqPortF);

  a_r9_cmp_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (irqCmp && !ackCmp) |=> irqCmp);

  a_r9_cmp_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqCmp) |-> $past(cmpEnable));

  a_r10_cmp_pins_input: assert property (@(posedge clk) disable iff (!rstN)
    cmpEnable |-> (pinOe[PIN_LO +: 2] == 2'b00));
endmodule

bind gpio_bank gpio_bank_checker #(
  .NUM_BIDIR(NUM_BIDIR), .PORT_W(PORT_W), .OUT_W(OUT_W), .DATA_W(DATA_W),
  .ADDR_W(ADDR_W), .CMP_PORT(CMP_PORT), .CMP_LO(CMP_LO)
) u_checker (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
  .busWrData(busWrData), .pinOe(pinOe), .portGOut(portGOut),
  .irqPortF(irqPortF), .irqCmp(irqCmp), .cmpEnable(cmpEnable)
);

// File: tb/test_gpio_bank.sv
module test_gpio_bank;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [5:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [15:0] busWrData = '0;
  logic [15:0] busRdData;
  logic [39:0] pinIn = '0;
  logic [39:0] pinOut, pinOe;
  logic [7:0]  portFIn = '0;
  logic        pullUpEnF;
  logic [15:0] portGOut;
  logic        cmpIn = 1'b0;
  logic        irqPortF, irqCmp;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  gpio_bank i_gpio_bank (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .pinIn(pinIn),
    .pinOut(pinOut), .pinOe(pinOe), .portFIn(portFIn), .pullUpEnF(pullUpEnF),
    .portGOut(portGOut), .cmpIn(cmpIn), .irqPortF(irqPortF), .irqCmp(irqCmp)
  );

  task automatic check(input string tag, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(posedge clk); #1;
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [5:0] a, output logic [15:0] d);
    @(negedge clk);
    busAddr = a; busWrEn = 1'b0;
    #1 d = busRdData;
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd;
    logic [7:0] dirPat [4] = '{8'h00, 8'hFF, 8'hA5, 8'h3C};
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 oe", pinOe, 40'h0);
    check("R1 out", pinOut, 40'h0);
    check("R1 g", {24'h0, portGOut}, 40'h0);
    check("R1 irq", {38'h0, irqPortF, irqCmp}, 40'h0);
    check("R1 pullup", {39'h0, pullUpEnF}, 40'h0);
    busRead(6'h30, rd); check("R1 cfg", {24'h0, rd}, 40'h0);

    // R2 R3 R4 sweep over ports and patterns
    for (int k = 0; k < 5; k++) begin
      for (int p = 0; p < 4; p++) begin
        logic [7:0] dir, lat, pin, exp;
        dir = dirPat[p] ^ 8'(k);
        lat = 8'h5A + 8'(k * 17) + 8'(p * 3);
        pin = 8'hC3 ^ 8'(p * 37) ^ 8'(k);
        @(negedge clk); pinIn = '0; pinIn[k*8 +: 8] = pin;
        busWrite(6'(k*8 + 4), {8'h00, dir});
        busWrite(6'(k*8), {8'hEE, lat});
        edges(2);
        exp = (pin & ~dir) | (lat & dir);
        check("R2 oe", {32'h0, pinOe[k*8 +: 8]}, {32'h0, dir});
        check("R3 out", {32'h0, pinOut[k*8 +: 8]}, {32'h0, lat});
        busRead(6'(k*8 + 4), rd); check("R2 dir readback", {24'h0, rd}, {32'h0, dir});
        busRead(6'(k*8), rd); check("R3 data readback", {24'h0, rd}, {32'h0, exp});
      end
    end
    // R4 other ports kept their last values
    for (int k = 0; k < 5; k++) begin
      logic [7:0] dirLast;
      dirLast = 8'h3C ^ 8'(k);
      check("R4 oe kept", {32'h0, pinOe[k*8 +: 8]}, {32'h0, dirLast});
      check("R4 latch kept", {32'h0, pinOut[k*8 +: 8]}, {32'h0, 8'h5A + 8'(k*17) + 8'd9});
    end

    // R3 sync latency on port 0, all inputs
    busWrite(6'h04, 16'h0000);
    @(negedge clk); pinIn[7:0] = 8'h00;
    edges(3);
    @(negedge clk); pinIn[7:0] = 8'hC3;
    @(posedge clk); #1 busAddr = 6'h00;
    @(negedge clk); check("R3 not after 1 edge", {24'h0, busRdData}, 40'h0);
    @(posedge clk); @(negedge clk); check("R3 after 2 edges", {24'h0, busRdData}, 40'hC3);

    // R5 R8 input-only port
    busWrite(6'h34, 16'h0003);
    @(negedge clk); portFIn = 8'h96;
    edges(2);
    check("R8 not after 2 edges", {39'h0, irqPortF}, 40'h0);
    busAddr = 6'h28; #1 check("R5 port F read", {24'h0, busRdData}, 40'h96);
    edges(1);
    check("R8 set after 3 edges", {39'h0, irqPortF}, 40'h1);
    busWrite(6'h28, 16'h00FF);
    busRead(6'h28, rd); check("R5 write ignored", {24'h0, rd}, 40'h96);
    busWrite(6'h34, 16'h0000);
    edges(1);
    check("R8 zero write keeps", {39'h0, irqPortF}, 40'h1);
    busRead(6'h34, rd); check("R8 status bit0", {24'h0, rd}, 40'h1);
    busWrite(6'h34, 16'h0001);
    edges(1);
    check("R8 ack clears", {39'h0, irqPortF}, 40'h0);

    // R7 configuration
    busWrite(6'h30, 16'h0001);
    check("R7 pullup", {39'h0, pullUpEnF}, 40'h1);
    busRead(6'h30, rd); check("R7 cfg readback", {24'h0, rd}, 40'h1);

    // R9 comparator disabled: no interrupt
    @(negedge clk); cmpIn = 1'b1;
    edges(4);
    check("R9 disabled no irq", {39'h0, irqCmp}, 40'h0);
    busWrite(6'h30, 16'h0007);
    @(negedge clk); cmpIn = 1'b0;
    edges(4);
    check("R9 falling ignored in rising mode", {39'h0, irqCmp}, 40'h0);
    @(negedge clk); cmpIn = 1'b1;
    edges(4);
    check("R9 rising sets", {39'h0, irqCmp}, 40'h1);
    busRead(6'h34, rd); check("R9 status bit1", {24'h0, rd}, 40'h2);
    busWrite(6'h34, 16'h0002);
    edges(1);
    check("R9 ack clears", {39'h0, irqCmp}, 40'h0);
    busWrite(6'h30, 16'h0003);
    @(negedge clk); cmpIn = 1'b0;
    edges(4);
    check("R9 falling sets", {39'h0, irqCmp}, 40'h1);
    busWrite(6'h34, 16'h0002);

    // R10 comparator pins forced to input
    busWrite(6'h1C, 16'h00FF);
    check("R10 forced input", {32'h0, pinOe[31:24]}, 40'hCF);
    busWrite(6'h30, 16'h0000);
    check("R10 released", {32'h0, pinOe[31:24]}, 40'hFF);

    // R6 output-only port walking ones
    for (int b = 0; b < 16; b++) begin
      logic [15:0] v;
      v = 16'h1 << b;
      busWrite(6'h2C, v);
      check("R6 g out", {24'h0, portGOut}, {24'h0, v});
      busRead(6'h2C, rd); check("R6 g readback", {24'h0, rd}, {24'h0, v});
    end
    busWrite(6'h2C, 16'hA55A);
    check("R6 g pattern", {24'h0, portGOut}, 40'hA55A);

    // R11 unmapped and misaligned
    busWrite(6'h3C, 16'hFFFF);
    busWrite(6'h02, 16'hFFFF);
    busWrite(6'h29, 16'hFFFF);
    busWrite(6'h06, 16'hFFFF);
    check("R11 g unchanged", {24'h0, portGOut}, 40'hA55A);
    check("R11 port0 oe unchanged", {32'h0, pinOe[7:0]}, 40'h0);
    busRead(6'h3C, rd); check("R11 unmapped reads 0", {24'h0, rd}, 40'h0);
    busRead(6'h02, rd); check("R11 misaligned reads 0", {24'h0, rd}, 40'h0);
    busRead(6'h30, rd); check("R11 cfg unchanged", {24'h0, rd}, 40'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule